// File: doc/BRIEF.md
# Offset-Corrected Result Register Pair

This block sits behind a calibrated converter that delivers 20-bit signed conversion results. Each result arrives with a one-cycle valid strobe. The block subtracts a programmable 16-bit signed offset from the result. The offset is scaled by sixteen, so that it lines up with the upper sixteen bits of the 20-bit word. The corrected value is stored in two read-only registers: a 16-bit high word and an 8-bit low byte. The low byte carries the four least significant result bits in its upper nibble.

A small register bus gives access to the block. A write port loads the offset register. A combinational read port returns the offset, the high word or the low byte, selected by a 2-bit address. If the subtraction leaves the 20-bit range, the result saturates to the nearest limit and does not wrap. A static mode input selects reduced resolution. In that mode only the top twelve result bits are kept, and the rest read as zero.

Top module: `offset_result_regs`

## Requirements
- R1: After reset the offset register, the high result word and the low result byte all read zero.
- R2: A write with address 0 loads the 16-bit two's complement offset, and reading address 0 returns it.
- R3: Writes to addresses 1, 2 and 3 change no register: the offset, the high word and the low byte keep their values.
- R4: On the clock edge where the valid strobe is high, the corrected value C = input − offset×16 is captured. Reading address 1 afterwards returns C[19:4]. Reading address 2 returns C[3:0] in bits 7:4, with bits 3:0 zero.
- R5: If C is above 524287, the stored value is 524287 (high word 7FFFh, low byte F0h). If C is below −524288, the stored value is −524288 (high word 8000h, low byte 00h).
- R6: While the valid strobe is low, both result registers hold their values, whatever the result input does.
- R7: When the reduced-resolution input is high, the captured value has bits 7:0 of C cleared after saturation. High-word bits 3:0 and the whole low byte then read zero.
- R8: A result strobed in the same cycle as an offset write is corrected with the offset held before that write.
- R9: Reading address 2 returns zero in bits 15:8. Reading address 3 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| resInValid | input | 1 | Strobe marking a new calibrated result |
| resIn | input | 20 | Calibrated conversion result, two's complement |
| lowRes | input | 1 | Static mode select: 1 keeps 12 significant bits |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Register write address (0 = offset) |
| wrData | input | 16 | Register write data |
| rdAddr | input | 2 | Register read address (0 offset, 1 high word, 2 low byte) |
| rdData | output | 16 | Register read data |

## Verification
Some properties are checked on every cycle. The result registers hold still when no strobe is present. The offset ignores writes to the read-only addresses. The result never flips sign against the operands: a non-negative input minus a negative offset never reads negative, and the reverse holds as well. Reduced resolution never leaves low-order bits set after a capture. The read map keeps its zero fields. The exact corrected values can only be shown by the bench's sweeps over offsets and inputs in both modes. So can the saturation limits, the reset contents and the same-cycle write ordering, with expected values computed arithmetically.

// File: rtl/orr_pkg.sv
package orr_pkg;
  // strobes from the control half to the datapath half
  typedef struct packed {
    logic loadOfs;
    logic capture;
  } ctrlStrobeT;

  localparam int ADDR_OFS = 0;
  localparam int ADDR_HI  = 1;
  localparam int ADDR_LO  = 2;
endpackage

// File: rtl/orr_ctrl.sv
module orr_ctrl
  import orr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              resInValid,
  output ctrlStrobeT        strobes
);
  // only the offset address is writable; all other addresses are read-only
  always_comb begin
    strobes.loadOfs = wrEn && (wrAddr == ADDR_W'(ADDR_OFS));
    strobes.capture = resInValid;
  end
endmodule

// File: rtl/orr_datapath.sv
module orr_datapath
  import orr_pkg::*;
#(
  parameter int IN_W     = 20,
  parameter int OFS_W    = 16,
  parameter int LO_W     = 8,
  parameter int RED_BITS = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [IN_W-1:0]   resIn,
  input  logic              lowRes,
  input  logic [OFS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [OFS_W-1:0]  rdData,
  output logic [OFS_W-1:0]  ofsQ,
  output logic [OFS_W-1:0]  hiQ,
  output logic [LO_W-1:0]   loQ
);
  localparam int FRAC_W = IN_W - OFS_W;
  localparam int DIFF_W = IN_W + 2;
  localparam int GUARD  = DIFF_W - IN_W + 1;
  localparam logic [IN_W-1:0] POS_LIM = {1'b0, {(IN_W-1){1'b1}}};
  localparam logic [IN_W-1:0] NEG_LIM = {1'b1, {(IN_W-1){1'b0}}};

  logic signed [DIFF_W-1:0] inExt, ofsExt, diff;
  logic [GUARD-1:0]         guardBits;
  logic                     overflow;
  logic [IN_W-1:0]          satVal, keptVal;

  assign inExt  = {{(DIFF_W-IN_W){resIn[IN_W-1]}}, resIn};
  assign ofsExt = {{(DIFF_W-OFS_W-FRAC_W){ofsQ[OFS_W-1]}}, ofsQ, {FRAC_W{1'b0}}};
  assign diff   = inExt - ofsExt;

  // overflow when the bits above the 20-bit sign disagree
  assign guardBits = diff[DIFF_W-1:IN_W-1];
  assign overflow  = !((&guardBits) || !(|guardBits));

  always_comb begin
    if (overflow) satVal = diff[DIFF_W-1] ? NEG_LIM : POS_LIM;
    else          satVal = diff[IN_W-1:0];
  end

  generate
    if (RED_BITS > 0) begin : g_reduce
      localparam logic [IN_W-1:0] RED_MASK = {{(IN_W-RED_BITS){1'b1}}, {RED_BITS{1'b0}}};
      assign keptVal = lowRes ? (satVal & RED_MASK) : satVal;
    end else begin : g_full
      logic unusedMode;
      assign unusedMode = lowRes;
      assign keptVal = satVal;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ofsQ <= '0;
    end else if (strobes.loadOfs) begin
      ofsQ <= wrData;
    end
  end

  // both result registers load on the same edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ <= '0;
      loQ <= '0;
    end else if (strobes.capture) begin
      hiQ <= keptVal[IN_W-1:FRAC_W];
      loQ <= {keptVal[FRAC_W-1:0], {(LO_W-FRAC_W){1'b0}}};
    end
  end

  always_comb begin
    case (rdAddr)
      ADDR_W'(ADDR_OFS): rdData = ofsQ;
      ADDR_W'(ADDR_HI):  rdData = hiQ;
      ADDR_W'(ADDR_LO):  rdData = {{(OFS_W-LO_W){1'b0}}, loQ};
      default:           rdData = '0;
    endcase
  end
endmodule

// File: rtl/offset_result_regs.sv
module offset_result_regs
  import orr_pkg::*;
#(
  parameter int IN_W     = 20,
  parameter int OFS_W    = 16,
  parameter int LO_W     = 8,
  parameter int RED_BITS = 8,
  parameter int ADDR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resInValid,
  input  logic [IN_W-1:0]   resIn,
  input  logic              lowRes,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [OFS_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [OFS_W-1:0]  rdData
);
  ctrlStrobeT        strobes;
  logic [OFS_W-1:0]  ofsReg;
  logic [OFS_W-1:0]  hiReg;
  logic [LO_W-1:0]   loReg;

  orr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .resInValid (resInValid),
    .strobes    (strobes)
  );

  orr_datapath #(
    .IN_W(IN_W), .OFS_W(OFS_W), .LO_W(LO_W), .RED_BITS(RED_BITS), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .resIn   (resIn),
    .lowRes  (lowRes),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .ofsQ    (ofsReg),
    .hiQ     (hiReg),
    .loQ     (loReg)
  );
endmodule

// File: rtl/offset_result_regs_chk.sv
module offset_result_regs_chk (
  input logic        clk,
  input logic        rstN,
  input logic        resInValid,
  input logic [19:0] resIn,
  input logic        lowRes,
  input logic        wrEn,
  input logic [1:0]  wrAddr,
  input logic [1:0]  rdAddr,
  input logic [15:0] rdData,
  input logic [15:0] ofsReg,
  input logic [15:0] hiReg,
  input logic [7:0]  loReg
);
  assert_ro_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 2'd0) |=> $stable(ofsReg));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !resInValid |=> ($stable(hiReg) && $stable(loReg)));

  assert_no_wrap_pos_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resInValid && !resIn[19] && ofsReg[15]) |=> !hiReg[15]);

  assert_no_wrap_neg_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resInValid && resIn[19] && !ofsReg[15]) |=> hiReg[15]);

  assert_reduced_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (resInValid && lowRes) |=> (hiReg[3:0] == 4'd0 && loReg == 8'd0));

  assert_read_map_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((rdAddr == 2'd2) |-> (rdData[15:8] == 8'd0 && rdData[3:0] == 4'd0)) and
    ((rdAddr == 2'd3) |-> (rdData == 16'd0)));
endmodule

bind offset_result_regs offset_result_regs_chk u_chk (
  .clk(clk), .rstN(rstN), .resInValid(resInValid), .resIn(resIn),
  .lowRes(lowRes), .wrEn(wrEn), .wrAddr(wrAddr), .rdAddr(rdAddr),
  .rdData(rdData), .ofsReg(ofsReg), .hiReg(hiReg), .loReg(loReg)
);

// File: tb/sim_offset_result_regs.sv
module sim_offset_result_regs;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resInValid = 1'b0;
  logic [19:0] resIn = '0;
  logic        lowRes = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;

  int total = 0;
  int bad = 0;
  int curOfs = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  offset_result_regs u0 (
    .clk(clk), .rstN(rstN), .resInValid(resInValid), .resIn(resIn),
    .lowRes(lowRes), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    if (a == 2'd0) curOfs = int'($signed(d));
  endtask

  task automatic push(input int v);
    @(negedge clk);
    resIn = 20'(v); resInValid = 1'b1;
    @(negedge clk);
    resInValid = 1'b0;
  endtask

  // expected 20-bit stored value from the requirements
  function automatic logic [19:0] model(input int v, input int ofs, input logic red);
    longint c;
    logic [19:0] r;
    c = longint'(v) - longint'(ofs) * 16;
    if (c > 524287) c = 524287;
    if (c < -524288) c = -524288;
    r = 20'(c);
    if (red) r[7:0] = 8'd0;
    return r;
  endfunction

  task automatic checkResult(input string req, input logic [19:0] e);
    logic [15:0] d;
    rd(2'd1, d); chk(req, d, e[19:4]);
    rd(2'd2, d); chk(req, d, {8'd0, e[3:0], 4'd0});
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    curOfs = 0;
  endtask

  task automatic sweep(input logic red);
    int ofsList[9] = '{0, 1, -1, 32767, -32768, 12345, -20000, 256, -4096};
    foreach (ofsList[i]) begin
      logic [15:0] d;
      wr(2'd0, 16'(ofsList[i]));
      rd(2'd0, d); chk("R2", d, 16'(ofsList[i]));
      for (int k = 0; k <= 256; k++) begin
        int v;
        v = (k == 256) ? 524287 : (k * 4096 - 524288 + (k % 7));
        push(v);
        checkResult(red ? "R7" : "R4/R5", model(v, curOfs, red));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    doReset();
    // R1 reset contents
    rd(2'd0, d); chk("R1", d, 16'h0000);
    rd(2'd1, d); chk("R1", d, 16'h0000);
    rd(2'd2, d); chk("R1", d, 16'h0000);
    // R9 unused address
    rd(2'd3, d); chk("R9", d, 16'h0000);

    // R4 simple capture with zero offset
    push(20'h12345);
    checkResult("R4", 20'h12345);

    // R3 writes to read-only addresses
    wr(2'd1, 16'hABCD);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'h5555);
    rd(2'd0, d); chk("R3", d, 16'h0000);
    rd(2'd1, d); chk("R3", d, 16'h1234);
    rd(2'd2, d); chk("R3", d, 16'h0050);
    rd(2'd3, d); chk("R9", d, 16'h0000);

    // R6 hold while strobe low
    @(negedge clk); resIn = 20'hFFFFF;
    repeat (4) @(negedge clk);
    resIn = 20'h00001;
    @(negedge clk);
    checkResult("R6", 20'h12345);

    // R5 directed saturation
    wr(2'd0, 16'h8000);
    push(524287);
    checkResult("R5", 20'h7FFFF);
    wr(2'd0, 16'h7FFF);
    push(-524288);
    checkResult("R5", 20'h80000);

    // R8 same-cycle offset write uses old offset (0x7FFF)
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd0; wrData = 16'h0001;
    resIn = 20'(1000); resInValid = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; resInValid = 1'b0;
    checkResult("R8", model(1000, 32767, 1'b0));
    curOfs = 1;
    push(1000);
    checkResult("R8", model(1000, 1, 1'b0));

    // full-resolution sweep
    sweep(1'b0);

    // reduced-resolution sweep
    @(negedge clk);
    lowRes = 1'b1;
    doReset();
    sweep(1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule